// File: doc/BRIEF.md
# Merging Miss Status Holding Table

This block records cache-line misses that are still waiting for memory, keyed by block address. A first miss to a line claims a free slot. Later misses to the same line join that slot instead of claiming a new one. Each slot keeps its request identifiers in arrival order, up to a fixed per-line limit, and keeps a sticky flag that is set once any joined request is atomic.

The surrounding cache uses the block in four ways:

- It presents an address on the probe port. It learns in the same cycle whether that line is already pending and whether one more request for it could be taken.
- It adds requests.
- When a fill comes back, it marks that line ready. One cycle later it receives the slot's atomic flag, or an error pulse if no slot holds that address.
- Marked lines form a response queue. While the queue is non-empty, the consumer pops one request identifier per cycle. The identifiers come from the line at the head of the queue, oldest first. A slot is freed in the cycle its last identifier leaves, and the queue moves on to the next marked line.

Top module: `mshr_merge_table`

## Requirements
- R1: After reset no slot is in use: probe_hit, probe_full, access_ready, ready_atomic and ready_err are all 0.
- R2: probe_hit is 1 in the same cycle exactly when a slot in use holds probe_addr.
- R3: probe_full is 1 when probe_addr has a slot that already holds MAX_MERGE identifiers, or when probe_addr has no slot and all SLOTS slots are in use; otherwise it is 0.
- R4: An add to an address with a non-full slot appends the identifier to that slot. An add to a new address claims a free slot. An add that finds the table full for its address has no effect on any slot.
- R5: The slot's atomic flag is set by any atomic add and stays set until the slot is freed. ready_atomic shows the flag for the marked line one cycle after ready_valid.
- R6: Marking an address that has no slot raises ready_err for one cycle, one cycle after ready_valid, and leaves the response queue unchanged.
- R7: access_ready is 1 exactly while the response queue holds at least one marked line. It rises the cycle after the marking.
- R8: pop_id and pop_addr show the oldest identifier of the line at the head of the response queue. Lines drain in the order they were marked, and each line drains in the order of its adds.
- R9: In the cycle a line's last identifier is popped, its slot is freed and the line is removed from the response queue. probe_hit for that address is 0 afterwards.
- R10: A pop while access_ready is 0 has no effect.
- R11: An add that merges into a line in the same cycle as that line's last pop keeps the line alive and queued. The new identifier is popped next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| probe_addr | input | ADDR_W | Block address to query |
| probe_hit | output | 1 | A slot holds probe_addr |
| probe_full | output | 1 | No request for probe_addr can be taken now |
| add_valid | input | 1 | Add a request this cycle |
| add_addr | input | ADDR_W | Block address of the added request |
| add_id | input | ID_W | Identifier of the added request |
| add_atomic | input | 1 | The added request is atomic |
| ready_valid | input | 1 | A fill returned for ready_addr |
| ready_addr | input | ADDR_W | Block address of the returned fill |
| ready_atomic | output | 1 | Atomic flag of the line marked last cycle |
| ready_err | output | 1 | The line marked last cycle had no slot |
| access_ready | output | 1 | Response queue is non-empty |
| pop | input | 1 | Consume the identifier shown on pop_id |
| pop_id | output | ID_W | Oldest identifier of the head line |
| pop_addr | output | ADDR_W | Block address of the head line |

## Verification
The bench probes the two meanings of full separately. A design that mixed up the per-line limit and the slot count would accept a fourth merge, or would refuse a fresh line while slots were free. It also fills all slots and then tries a fifth address, which a broken drop path would store or let overwrite a live slot. Drain order is checked with lines marked in a different order from their allocation, so a design that drained by slot index would return the wrong identifier.

The release corner is driven on purpose: a merge lands in the same cycle as a line's last pop. A design that released regardless would lose the new identifier and drop access_ready. Pops with an empty queue are followed by a full use of the queue, which exposes any pointer that drifted.

// File: rtl/mshr_merge_pkg.sv
package mshr_merge_pkg;
  // Outcome of the add port in one cycle.
  typedef enum logic [1:0] {
    ADD_IDLE  = 2'd0,
    ADD_MERGE = 2'd1,
    ADD_ALLOC = 2'd2,
    ADD_DROP  = 2'd3
  } add_kind_e;
endpackage

// File: rtl/mshr_cam.sv
// Fully associative compare of one key against every slot tag.
module mshr_cam #(
  parameter int SLOTS  = 4,
  parameter int ADDR_W = 16,
  localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic [SLOTS-1:0]  valid_i,
  input  logic [ADDR_W-1:0] tags_i [SLOTS],
  input  logic [ADDR_W-1:0] key_i,
  output logic [SLOTS-1:0]  match_o,
  output logic              hit_o,
  output logic [IDX_W-1:0]  idx_o
);
  for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
    assign match_o[g] = valid_i[g] && (tags_i[g] == key_i);
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (match_o[i]) idx_o = IDX_W'(i);
    end
  end

  assign hit_o = |match_o;
endmodule

// File: rtl/mshr_slot.sv
// One slot: tag, sticky atomic flag and an in-order identifier queue.
module mshr_slot #(
  parameter int ADDR_W    = 16,
  parameter int ID_W      = 8,
  parameter int MAX_MERGE = 3,
  localparam int CNT_W = $clog2(MAX_MERGE + 1),
  localparam int PTR_W = (MAX_MERGE > 1) ? $clog2(MAX_MERGE) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_i,
  input  logic              merge_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ID_W-1:0]   id_i,
  input  logic              atomic_i,
  input  logic              pop_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              atomic_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              full_o,
  output logic [ID_W-1:0]   head_id_o
);
  localparam logic [CNT_W-1:0] CAP  = CNT_W'(MAX_MERGE);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(MAX_MERGE - 1);

  logic [ID_W-1:0]  id_mem [MAX_MERGE];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt_nxt;
  logic             push;

  assign push    = alloc_i || merge_i;
  assign cnt_nxt = cnt_o + CNT_W'(push) - CNT_W'(pop_i);

  // Storage without reset so it can map to distributed RAM.
  always_ff @(posedge clk) begin
    if (push) id_mem[wr_ptr] <= id_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o  <= 1'b0;
      addr_o   <= '0;
      atomic_o <= 1'b0;
      cnt_o    <= '0;
      wr_ptr   <= '0;
      rd_ptr   <= '0;
    end else begin
      if (alloc_i) begin
        valid_o  <= 1'b1;
        addr_o   <= addr_i;
        atomic_o <= atomic_i;
      end else if (merge_i) begin
        atomic_o <= atomic_o | atomic_i;
      end
      if (pop_i && !push && cnt_nxt == '0) valid_o <= 1'b0;
      if (push)  wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop_i) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      cnt_o <= cnt_nxt;
    end
  end

  assign full_o    = (cnt_o == CAP);
  assign head_id_o = id_mem[rd_ptr];

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
    push |-> cnt_o < CAP);
  p_alloc_free_r4: assert property (@(posedge clk) disable iff (rst)
    alloc_i |-> !valid_o);
  p_pop_nonempty_r8: assert property (@(posedge clk) disable iff (rst)
    pop_i |-> (valid_o && cnt_o != '0));
endmodule

// File: rtl/mshr_ready_fifo.sv
// Response-order queue of slot indices.
module mshr_ready_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 2,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push_i,
  input  logic [W-1:0] push_data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         nonempty_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CAP  = CNT_W'(DEPTH);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (push_i) mem[wr_ptr] <= push_data_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_i) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop_i)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      cnt <= cnt + CNT_W'(push_i) - CNT_W'(pop_i);
    end
  end

  assign head_o     = mem[rd_ptr];
  assign nonempty_o = (cnt != '0);

  p_queue_room_r7: assert property (@(posedge clk) disable iff (rst)
    (push_i && !pop_i) |-> cnt < CAP);
  p_queue_pop_r9: assert property (@(posedge clk) disable iff (rst)
    pop_i |-> nonempty_o);
endmodule

// File: rtl/mshr_merge_table.sv
module mshr_merge_table
  import mshr_merge_pkg::*;
#(
  parameter int SLOTS     = 4,
  parameter int MAX_MERGE = 3,
  parameter int ADDR_W    = 16,
  parameter int ID_W      = 8,
  localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int CNT_W = $clog2(MAX_MERGE + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] probe_addr,
  output logic              probe_hit,
  output logic              probe_full,
  input  logic              add_valid,
  input  logic [ADDR_W-1:0] add_addr,
  input  logic [ID_W-1:0]   add_id,
  input  logic              add_atomic,
  input  logic              ready_valid,
  input  logic [ADDR_W-1:0] ready_addr,
  output logic              ready_atomic,
  output logic              ready_err,
  output logic              access_ready,
  input  logic              pop,
  output logic [ID_W-1:0]   pop_id,
  output logic [ADDR_W-1:0] pop_addr
);
  logic [SLOTS-1:0]  s_valid, s_atomic, s_full;
  logic [ADDR_W-1:0] s_addr [SLOTS];
  logic [CNT_W-1:0]  s_cnt  [SLOTS];
  logic [ID_W-1:0]   s_head [SLOTS];
  logic [SLOTS-1:0]  s_alloc, s_merge, s_pop;

  logic [SLOTS-1:0] p_match, a_match, r_match;
  logic             p_hit, a_hit, r_hit;
  logic [IDX_W-1:0] p_idx, a_idx, r_idx;

  logic [IDX_W-1:0] free_idx, q_head;
  logic             any_free, pop_go, q_pop, q_push;
  add_kind_e        add_kind;

  mshr_cam #(.SLOTS(SLOTS), .ADDR_W(ADDR_W)) u_cam_probe (
    .valid_i(s_valid), .tags_i(s_addr), .key_i(probe_addr),
    .match_o(p_match), .hit_o(p_hit), .idx_o(p_idx));
  mshr_cam #(.SLOTS(SLOTS), .ADDR_W(ADDR_W)) u_cam_add (
    .valid_i(s_valid), .tags_i(s_addr), .key_i(add_addr),
    .match_o(a_match), .hit_o(a_hit), .idx_o(a_idx));
  mshr_cam #(.SLOTS(SLOTS), .ADDR_W(ADDR_W)) u_cam_ready (
    .valid_i(s_valid), .tags_i(s_addr), .key_i(ready_addr),
    .match_o(r_match), .hit_o(r_hit), .idx_o(r_idx));

  // Lowest free slot.
  always_comb begin
    free_idx = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (!s_valid[i]) free_idx = IDX_W'(i);
    end
  end
  assign any_free = ~&s_valid;

  assign probe_hit  = p_hit;
  assign probe_full = p_hit ? s_full[p_idx] : !any_free;

  always_comb begin
    if (!add_valid)              add_kind = ADD_IDLE;
    else if (a_hit)              add_kind = s_full[a_idx] ? ADD_DROP : ADD_MERGE;
    else                         add_kind = any_free ? ADD_ALLOC : ADD_DROP;
  end

  assign pop_go = pop && access_ready;
  assign q_push = ready_valid && r_hit;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign s_alloc[g] = (add_kind == ADD_ALLOC) && (free_idx == IDX_W'(g));
    assign s_merge[g] = (add_kind == ADD_MERGE) && (a_idx == IDX_W'(g));
    assign s_pop[g]   = pop_go && (q_head == IDX_W'(g));

    mshr_slot #(.ADDR_W(ADDR_W), .ID_W(ID_W), .MAX_MERGE(MAX_MERGE)) u_slot (
      .clk(clk), .rst(rst),
      .alloc_i(s_alloc[g]), .merge_i(s_merge[g]),
      .addr_i(add_addr), .id_i(add_id), .atomic_i(add_atomic),
      .pop_i(s_pop[g]),
      .valid_o(s_valid[g]), .addr_o(s_addr[g]), .atomic_o(s_atomic[g]),
      .cnt_o(s_cnt[g]), .full_o(s_full[g]), .head_id_o(s_head[g]));
  end

  // Head line leaves the queue when its last identifier goes and nothing joins.
  assign q_pop = pop_go && (s_cnt[q_head] == CNT_W'(1)) && !s_merge[q_head];

  mshr_ready_fifo #(.DEPTH(SLOTS), .W(IDX_W)) u_rq (
    .clk(clk), .rst(rst),
    .push_i(q_push), .push_data_i(r_idx), .pop_i(q_pop),
    .head_o(q_head), .nonempty_o(access_ready));

  assign pop_id   = s_head[q_head];
  assign pop_addr = s_addr[q_head];

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_atomic <= 1'b0;
      ready_err    <= 1'b0;
    end else begin
      ready_atomic <= q_push && s_atomic[r_idx];
      ready_err    <= ready_valid && !r_hit;
    end
  end

  p_unique_tag_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(p_match) && $onehot0(a_match) && $onehot0(r_match));
  p_head_live_r7: assert property (@(posedge clk) disable iff (rst)
    access_ready |-> s_valid[q_head]);
  p_err_cause_r6: assert property (@(posedge clk) disable iff (rst)
    ready_err |-> $past(ready_valid));
  p_release_r9: assert property (@(posedge clk) disable iff (rst)
    q_pop |=> !s_valid[$past(q_head)]);
  p_atomic_src_r5: assert property (@(posedge clk) disable iff (rst)
    ready_atomic |-> !ready_err);
endmodule

// File: tb/mshr_merge_table_tb.sv
module mshr_merge_table_tb_top;
  localparam int SLOTS = 4, MAXM = 3, AW = 16, IW = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic [AW-1:0] probe_addr = '0, add_addr = '0, ready_addr = '0, pop_addr;
  logic [IW-1:0] add_id = '0, pop_id;
  logic add_valid = 0, add_atomic = 0, ready_valid = 0, pop = 0;
  logic probe_hit, probe_full, ready_atomic, ready_err, access_ready;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mshr_merge_table #(.SLOTS(SLOTS), .MAX_MERGE(MAXM), .ADDR_W(AW), .ID_W(IW)) dut_i (
    .clk(clk), .rst(rst), .probe_addr(probe_addr), .probe_hit(probe_hit),
    .probe_full(probe_full), .add_valid(add_valid), .add_addr(add_addr),
    .add_id(add_id), .add_atomic(add_atomic), .ready_valid(ready_valid),
    .ready_addr(ready_addr), .ready_atomic(ready_atomic), .ready_err(ready_err),
    .access_ready(access_ready), .pop(pop), .pop_id(pop_id), .pop_addr(pop_addr));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_add(logic [AW-1:0] a, logic [IW-1:0] id, logic at);
    @(negedge clk);
    add_valid = 1; add_addr = a; add_id = id; add_atomic = at;
    @(negedge clk);
    add_valid = 0; add_atomic = 0;
  endtask

  task automatic do_mark(logic [AW-1:0] a, logic exp_at, logic exp_err, string tag);
    @(negedge clk);
    ready_valid = 1; ready_addr = a;
    @(negedge clk);
    ready_valid = 0;
    #1;
    check({tag, " ready_atomic"}, ready_atomic, exp_at);
    check({tag, " ready_err"}, ready_err, exp_err);
  endtask

  task automatic do_pop(logic [IW-1:0] exp_id, logic [AW-1:0] exp_a, string tag);
    @(negedge clk);
    #1;
    check({tag, " access_ready"}, access_ready, 1);
    check({tag, " pop_id"}, pop_id, exp_id);
    check({tag, " pop_addr"}, pop_addr, exp_a);
    pop = 1;
    @(negedge clk);
    pop = 0;
  endtask

  task automatic do_probe(logic [AW-1:0] a, logic exp_hit, logic exp_full, string tag);
    @(negedge clk);
    probe_addr = a;
    #1;
    check({tag, " probe_hit"}, probe_hit, exp_hit);
    check({tag, " probe_full"}, probe_full, exp_full);
  endtask

  task automatic t_reset();
    #1;
    check("R1 probe_hit", probe_hit, 0);
    check("R1 probe_full", probe_full, 0);
    check("R1 access_ready", access_ready, 0);
    check("R1 ready_atomic", ready_atomic, 0);
    check("R1 ready_err", ready_err, 0);
  endtask

  task automatic t_merge_and_drain();
    do_add(16'h0A00, 8'd1, 0);
    do_add(16'h0A00, 8'd2, 0);
    do_add(16'h0B00, 8'd3, 0);
    do_probe(16'h0A00, 1, 0, "R2 R3 hit not full");
    do_probe(16'h0C00, 0, 0, "R2 miss");
    do_add(16'h0A00, 8'd4, 0);
    do_probe(16'h0A00, 1, 1, "R3 line at limit");
    do_add(16'h0A00, 8'd5, 0);
    do_mark(16'h0B00, 0, 0, "R5 plain line");
    #1 check("R7 access_ready after mark", access_ready, 1);
    do_mark(16'h0A00, 0, 0, "R5 plain line A");
    do_pop(8'd3, 16'h0B00, "R8 first marked first");
    do_probe(16'h0B00, 0, 0, "R9 released");
    do_pop(8'd1, 16'h0A00, "R8 oldest");
    do_pop(8'd2, 16'h0A00, "R8 second");
    do_pop(8'd4, 16'h0A00, "R4 R8 third, dropped id5 absent");
    #1 check("R9 queue empty", access_ready, 0);
    do_probe(16'h0A00, 0, 0, "R9 R4 line freed");
  endtask

  task automatic t_idle_pop();
    @(negedge clk); pop = 1;
    @(negedge clk); pop = 0;
    #1 check("R10 still empty", access_ready, 0);
    do_add(16'h0C00, 8'd9, 0);
    do_mark(16'h0C00, 0, 0, "R10 mark");
    do_pop(8'd9, 16'h0C00, "R10 queue intact");
    #1 check("R10 empty again", access_ready, 0);
  endtask

  task automatic t_full_table();
    do_add(16'h1000, 8'd10, 0);
    do_add(16'h1100, 8'd11, 0);
    do_add(16'h1200, 8'd12, 0);
    do_add(16'h1300, 8'd13, 0);
    do_probe(16'h1400, 0, 1, "R3 all slots used");
    do_probe(16'h1100, 1, 0, "R3 existing line not full");
    do_add(16'h1400, 8'd14, 0);
    do_probe(16'h1400, 0, 1, "R4 fifth line dropped");
    do_add(16'h1200, 8'd15, 1);
    do_add(16'h1200, 8'd16, 0);
    do_mark(16'h7700, 0, 1, "R6 absent line");
    #1 check("R6 queue unchanged", access_ready, 0);
    do_mark(16'h1200, 1, 0, "R5 sticky atomic");
    do_mark(16'h1000, 0, 0, "R5 non-atomic");
    do_mark(16'h1300, 0, 0, "R5 non-atomic 2");
    do_mark(16'h1100, 0, 0, "R5 non-atomic 3");
    do_pop(8'd12, 16'h1200, "R8 mark order");
    do_pop(8'd15, 16'h1200, "R8 merge order");
    do_pop(8'd16, 16'h1200, "R8 merge order 2");
    do_pop(8'd10, 16'h1000, "R8 next line");
    do_pop(8'd13, 16'h1300, "R8 next line 2");
    do_pop(8'd11, 16'h1100, "R8 last line");
    #1 check("R9 all drained", access_ready, 0);
    do_probe(16'h1400, 0, 0, "R3 slots free again");
  endtask

  task automatic t_merge_on_last_pop();
    do_add(16'h2000, 8'd20, 0);
    do_mark(16'h2000, 0, 0, "R11 mark");
    @(negedge clk);
    #1 check("R11 head id", pop_id, 8'd20);
    pop = 1; add_valid = 1; add_addr = 16'h2000; add_id = 8'd21;
    @(negedge clk);
    pop = 0; add_valid = 0;
    #1 check("R11 line stays queued", access_ready, 1);
    do_probe(16'h2000, 1, 0, "R11 line alive");
    do_pop(8'd21, 16'h2000, "R11 new id next");
    #1 check("R11 released after", access_ready, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_merge_and_drain();
    t_idle_pop();
    t_full_table();
    t_merge_on_last_pop();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule